// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

Two identical 8-input priority interrupt controllers, wired as a master and a slave. The request output of the slave drives master input 2, so the pair serves 15 request lines. Each line is edge-triggered. A controller latches a rising edge, gates it through its mask and resolves it at fixed priority against its in-service set. The processor then runs a two-strobe acknowledge. The first strobe commits the winner to in-service. The second strobe returns an 8-bit vector.

Software programs each controller through a byte-wide write port. The port has a controller select and a one-bit offset. A start word on offset 0 opens a three-word setup on offset 1: vector base, cascade word, mode word. After setup, offset 1 writes the mask and offset 0 carries the end-of-interrupt command. The master places the number of a cascaded winner on a 3-bit cascade bus. The slave answers only when that code equals its programmed identity. In this wiring the identity must be 2.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, int_o, cas_vld_o and vec_vld_o are low, every mask bit is 0 and every in-service bit is 0.
- R2: A rising edge on an irq_i line latches a request. A line held high yields no second request. irq_i[2] has no effect on any output.
- R3: Writing the mask (offset 1, setup finished) sets or clears blocking per line (1 = blocked). A blocked request stays latched and is forwarded once its mask bit is cleared.
- R4: Priority is fixed, with input 0 highest. int_o is high only when the best unmasked request beats the best in-service bit of that controller.
- R5: Offset 0 with data bit 4 set starts setup and clears mask, in-service and request bits. The next three offset-1 writes load the vector base (bits 7:3), the cascade word and the mode word (bit 1 auto end-of-interrupt, bit 4 special nesting).
- R6: On ack1_i the winner's in-service bit is set and its request cleared. On ack2_i the block returns {base[7:3], winning input} on vec_o, with vec_vld_o high in the following cycle.
- R7: When the master's winner has its bit set in the master cascade word, cas_o holds that input number and cas_vld_o stays high from the cycle after ack1_i through the ack2_i cycle. The slave returns the vector only if cas_o equals bits 2:0 of its cascade word. Otherwise vec_vld_o stays low.
- R8: Masking master input 2 blocks every slave request from reaching int_o.
- R9: An offset-0 write with bits 7:3 = 00100 clears the highest-priority in-service bit of the addressed controller.
- R10: With auto end-of-interrupt set, the in-service bit is cleared at ack2_i.
- R11: With special nesting set on the master, a new request on a cascade input already in service raises int_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | 0 master, 1 slave |
| wr_a0_i | input | 1 | Port offset |
| wr_data_i | input | 8 | Write data |
| irq_i | input | 16 | [7:0] master lines, [15:8] slave lines, bit 2 unused |
| ack1_i | input | 1 | First acknowledge strobe |
| ack2_i | input | 1 | Second acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| cas_o | output | 3 | Cascade code from the master |
| cas_vld_o | output | 1 | Cascade code valid |
| vec_o | output | 8 | Returned vector |
| vec_vld_o | output | 1 | Vector valid |

## Verification
A wrong in-service bit or request bit shows at int_o no later than the next clock. Such a fault either raises a request that should wait or holds back one that should win. The fault shows later as a wrong vector byte, one cycle after ack2_i. A slip in the cascade sequence shows on cas_o and cas_vld_o in the cycle after ack1_i, or as a missing vector pulse. The bench holds a behavioural model and compares every output on every clock, so a divergence is reported in the cycle it first reaches a pin.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int LINES  = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int BASE_W = DATA_W - IDX_W;

  typedef enum logic [1:0] {CFG_RUN, CFG_BASE, CFG_CASC, CFG_MODE} cfg_st_e;

  localparam logic [4:0] CMD_NS_EOI = 5'b00100;  // data[7:3]
  localparam int BIT_INIT = 4;
  localparam int BIT_AEOI = 1;
  localparam int BIT_SFNM = 4;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import dic_pkg::*;
#(
  parameter  bit IS_SLAVE = 1'b0,
  parameter  int N        = LINES,
  localparam int IW       = $clog2(N),
  localparam int BW       = DATA_W - IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_a0_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [N-1:0]      irq_i,
  input  logic              ack1_i,
  input  logic              ack2_i,
  input  logic [IW-1:0]     cas_i,
  input  logic              cas_vld_i,
  output logic              int_o,
  output logic [IW-1:0]     cas_o,
  output logic              cas_vld_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_vld_o,
  output logic [N-1:0]      isr_o
);
  cfg_st_e           st_q;
  logic [N-1:0]      irq_q, irr_q, isr_q, mask_q;
  logic [N-1:0]      irr_n, isr_n;
  logic [DATA_W-1:0] casc_q;
  logic [BW-1:0]     base_q;
  logic              aeoi_q, sfnm_q;
  logic [DATA_W-1:0] vec_q;
  logic              vec_vld_q;

  logic          req_any, isr_any;
  logic [IW-1:0] req_idx, isr_idx;
  logic          nest_ok;

  logic          take_en, aclr_en, vec_ld;
  logic [IW-1:0] take_idx, aclr_idx, vec_idx;

  prio_pick #(.N(N)) u_req (.vec_i(irr_q & ~mask_q), .any_o(req_any), .idx_o(req_idx));
  prio_pick #(.N(N)) u_isr (.vec_i(isr_q),           .any_o(isr_any), .idx_o(isr_idx));

  assign nest_ok = sfnm_q && casc_q[req_idx] && isr_any && (isr_idx == req_idx);
  assign int_o   = req_any && (!isr_any || (req_idx < isr_idx) || nest_ok);

  // write decode
  logic wr_init, wr_eoi, wr_cfg;
  assign wr_init = wr_en_i && !wr_a0_i && wr_data_i[BIT_INIT];
  assign wr_eoi  = wr_en_i && !wr_a0_i && (wr_data_i[7:3] == CMD_NS_EOI) && (st_q == CFG_RUN);
  assign wr_cfg  = wr_en_i && wr_a0_i;

  generate
    if (!IS_SLAVE) begin : g_mst
      logic          pend_q, own_q, casv_q;
      logic [IW-1:0] win_q;
      logic          cas_unused;
      assign cas_unused = ^{cas_i, cas_vld_i};

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pend_q <= 1'b0;
          own_q  <= 1'b0;
          casv_q <= 1'b0;
          win_q  <= '0;
        end else begin
          if (ack2_i) begin
            pend_q <= 1'b0;
            casv_q <= 1'b0;
          end
          if (ack1_i) begin
            pend_q <= int_o;
            own_q  <= !casc_q[req_idx];
            casv_q <= int_o && casc_q[req_idx];
            win_q  <= req_idx;
          end
        end
      end

      assign take_en   = ack1_i && int_o;
      assign take_idx  = req_idx;
      assign aclr_en   = ack2_i && pend_q && aeoi_q;
      assign aclr_idx  = win_q;
      assign vec_ld    = ack2_i && pend_q && own_q;
      assign vec_idx   = win_q;
      assign cas_o     = win_q;
      assign cas_vld_o = casv_q;
    end else begin : g_slv
      logic id_hit;
      logic ack1_unused;
      assign ack1_unused = ack1_i;
      assign id_hit      = cas_vld_i && (cas_i == casc_q[IW-1:0]);

      assign take_en   = ack2_i && id_hit && int_o;
      assign take_idx  = req_idx;
      assign aclr_en   = take_en && aeoi_q;
      assign aclr_idx  = req_idx;
      assign vec_ld    = take_en;
      assign vec_idx   = req_idx;
      assign cas_o     = '0;
      assign cas_vld_o = 1'b0;
    end
  endgenerate

  always_comb begin
    irr_n = irr_q | (irq_i & ~irq_q);
    isr_n = isr_q;
    if (take_en) begin
      irr_n[take_idx] = 1'b0;
      isr_n[take_idx] = 1'b1;
    end
    if (aclr_en) isr_n[aclr_idx] = 1'b0;
    if (wr_eoi && isr_any) isr_n[isr_idx] = 1'b0;
    if (wr_init) begin
      irr_n = '0;
      isr_n = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= CFG_RUN;
      irq_q     <= '0;
      irr_q     <= '0;
      isr_q     <= '0;
      mask_q    <= '0;
      casc_q    <= '0;
      base_q    <= '0;
      aeoi_q    <= 1'b0;
      sfnm_q    <= 1'b0;
      vec_q     <= '0;
      vec_vld_q <= 1'b0;
    end else begin
      irq_q     <= irq_i;
      irr_q     <= irr_n;
      isr_q     <= isr_n;
      vec_vld_q <= vec_ld;
      if (vec_ld) vec_q <= {base_q, vec_idx};
      if (wr_init) begin
        st_q   <= CFG_BASE;
        mask_q <= '0;
        aeoi_q <= 1'b0;
        sfnm_q <= 1'b0;
      end else if (wr_cfg) begin
        unique case (st_q)
          CFG_BASE: begin base_q <= wr_data_i[DATA_W-1:IW]; st_q <= CFG_CASC; end
          CFG_CASC: begin casc_q <= wr_data_i;              st_q <= CFG_MODE; end
          CFG_MODE: begin
            aeoi_q <= wr_data_i[BIT_AEOI];
            sfnm_q <= wr_data_i[BIT_SFNM];
            st_q   <= CFG_RUN;
          end
          default:  mask_q <= wr_data_i[N-1:0];
        endcase
      end
    end
  end

  assign vec_o     = vec_q;
  assign vec_vld_o = vec_vld_q;
  assign isr_o     = isr_q;
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dic_pkg::*;
#(
  parameter  int CASC_IN = 2,
  localparam int NL      = LINES,
  localparam int IW      = $clog2(NL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic              wr_a0_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2*NL-1:0]   irq_i,
  input  logic              ack1_i,
  input  logic              ack2_i,
  output logic              int_o,
  output logic [IW-1:0]     cas_o,
  output logic              cas_vld_o,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_vld_o
);
  logic              slv_int, mst_vld, slv_vld;
  logic [DATA_W-1:0] mst_vec, slv_vec;
  logic [NL-1:0]     mst_irq, mst_isr, slv_isr;
  logic [IW-1:0]     slv_cas_unused;
  logic              slv_casv_unused;
  logic              irq_casc_unused;

  assign irq_casc_unused = irq_i[CASC_IN];

  always_comb begin
    mst_irq          = irq_i[NL-1:0];
    mst_irq[CASC_IN] = slv_int;
  end

  irq_unit #(.IS_SLAVE(1'b0), .N(NL)) u_mst (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en_i && !wr_sel_i),
    .wr_a0_i, .wr_data_i,
    .irq_i     (mst_irq),
    .ack1_i, .ack2_i,
    .cas_i     ('0),
    .cas_vld_i (1'b0),
    .int_o     (int_o),
    .cas_o     (cas_o),
    .cas_vld_o (cas_vld_o),
    .vec_o     (mst_vec),
    .vec_vld_o (mst_vld),
    .isr_o     (mst_isr)
  );

  irq_unit #(.IS_SLAVE(1'b1), .N(NL)) u_slv (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en_i && wr_sel_i),
    .wr_a0_i, .wr_data_i,
    .irq_i     (irq_i[2*NL-1:NL]),
    .ack1_i, .ack2_i,
    .cas_i     (cas_o),
    .cas_vld_i (cas_vld_o),
    .int_o     (slv_int),
    .cas_o     (slv_cas_unused),
    .cas_vld_o (slv_casv_unused),
    .vec_o     (slv_vec),
    .vec_vld_o (slv_vld),
    .isr_o     (slv_isr)
  );

  assign vec_vld_o = mst_vld || slv_vld;
  assign vec_o     = slv_vld ? slv_vec : mst_vec;
endmodule

// File: rtl/dual_irq_ctrl_chk.sv
module dual_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic       wr_a0_i,
  input logic [7:0] wr_data_i,
  input logic       ack1_i,
  input logic       ack2_i,
  input logic [2:0] cas_o,
  input logic       cas_vld_o,
  input logic       vec_vld_o,
  input logic [7:0] mst_isr,
  input logic [7:0] slv_isr
);
  p_cas_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_vld_o && !ack2_i) |=> (cas_vld_o && $stable(cas_o)));

  p_cas_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_vld_o) |-> $past(ack1_i));

  p_vec_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_vld_o |-> $past(ack2_i));

  p_slv_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(slv_isr) > $countones($past(slv_isr))) |-> $past(ack2_i && cas_vld_o));

  p_eoi_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && !wr_a0_i && wr_data_i[7:3] == 5'b00100 &&
     mst_isr != 8'h00 && !ack1_i && !ack2_i)
    |=> ($countones(mst_isr) + 1 == $countones($past(mst_isr))));
endmodule

bind dual_irq_ctrl dual_irq_ctrl_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_a0_i, .wr_data_i,
  .ack1_i, .ack2_i, .cas_o, .cas_vld_o, .vec_vld_o,
  .mst_isr, .slv_isr
);

// File: tb/sim_dual_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dual_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen = 1'b0, sel = 1'b0, a0 = 1'b0, ack1 = 1'b0, ack2 = 1'b0;
  logic [7:0] wd = '0;
  logic [15:0] irq = '0;
  logic int_w, casv_w, vecv_w;
  logic [2:0] cas_w;
  logic [7:0] vec_w;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen), .wr_sel_i(sel), .wr_a0_i(a0),
    .wr_data_i(wd), .irq_i(irq), .ack1_i(ack1), .ack2_i(ack2),
    .int_o(int_w), .cas_o(cas_w), .cas_vld_o(casv_w), .vec_o(vec_w), .vec_vld_o(vecv_w)
  );

  // behavioural reference model
  bit [7:0] m_irr[2], m_isr[2], m_mask[2], m_casc[2], m_prev[2];
  bit [4:0] m_base[2];
  bit m_aeoi[2], m_sfnm[2];
  int m_st[2];
  bit m_pend, m_own, m_casv, m_vecv;
  int m_win, m_cas;
  bit [7:0] m_vec;
  bit mi0, mi1, p_pend, p_own, p_casv;
  int mr0, mr1, ms[2], p_win, p_cas;
  bit [7:0] nin0;

  function automatic int lowest(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit mdl_int(int c);
    int r, s;
    r = lowest(m_irr[c] & ~m_mask[c]);
    if (r == 8) return 1'b0;
    s = lowest(m_isr[c]);
    return (s == 8) || (r < s) || (m_sfnm[c] && m_casc[c][r] && s == r);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_irr[c] = 0; m_isr[c] = 0; m_mask[c] = 0; m_casc[c] = 0; m_prev[c] = 0;
        m_base[c] = 0; m_aeoi[c] = 0; m_sfnm[c] = 0; m_st[c] = 0;
      end
      m_pend = 0; m_own = 0; m_casv = 0; m_vecv = 0; m_win = 0; m_cas = 0; m_vec = 0;
    end else begin
      mi0 = mdl_int(0); mi1 = mdl_int(1);
      mr0 = lowest(m_irr[0] & ~m_mask[0]); mr1 = lowest(m_irr[1] & ~m_mask[1]);
      ms[0] = lowest(m_isr[0]); ms[1] = lowest(m_isr[1]);
      p_pend = m_pend; p_own = m_own; p_win = m_win; p_casv = m_casv; p_cas = m_cas;
      nin0 = irq[7:0]; nin0[2] = mi1;
      m_irr[0] |= nin0 & ~m_prev[0];      m_prev[0] = nin0;
      m_irr[1] |= irq[15:8] & ~m_prev[1]; m_prev[1] = irq[15:8];
      m_vecv = 0;
      if (ack2) begin
        if (p_pend && p_own) begin m_vec = {m_base[0], 3'(p_win)}; m_vecv = 1; end
        if (p_pend && m_aeoi[0]) m_isr[0][p_win] = 0;
        m_casv = 0; m_pend = 0;
        if (p_casv && p_cas == int'(m_casc[1][2:0]) && mi1) begin
          m_irr[1][mr1] = 0;
          m_isr[1][mr1] = !m_aeoi[1];
          m_vec = {m_base[1], 3'(mr1)}; m_vecv = 1;
        end
      end
      if (ack1) begin
        m_pend = mi0; m_casv = 0;
        if (mi0) begin
          m_irr[0][mr0] = 0; m_isr[0][mr0] = 1; m_win = mr0;
          m_own = !m_casc[0][mr0]; m_casv = m_casc[0][mr0]; m_cas = mr0;
        end
      end
      if (wen) begin
        int c;
        c = sel ? 1 : 0;
        if (!a0 && wd[4]) begin
          m_st[c] = 1; m_mask[c] = 0; m_isr[c] = 0; m_irr[c] = 0; m_aeoi[c] = 0; m_sfnm[c] = 0;
        end else if (!a0) begin
          if (wd[7:3] == 5'b00100 && m_st[c] == 0 && ms[c] != 8) m_isr[c][ms[c]] = 0;
        end else begin
          case (m_st[c])
            1: begin m_base[c] = wd[7:3]; m_st[c] = 2; end
            2: begin m_casc[c] = wd; m_st[c] = 3; end
            3: begin m_aeoi[c] = wd[1]; m_sfnm[c] = wd[4]; m_st[c] = 0; end
            default: m_mask[c] = wd;
          endcase
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 int_o vs model", int'(int_w), int'(mdl_int(0)));
      check("R6 vec_vld_o vs model", int'(vecv_w), int'(m_vecv));
      if (m_vecv) check("R6 vec_o vs model", int'(vec_w), int'(m_vec));
      check("R7 cas_vld_o vs model", int'(casv_w), int'(m_casv));
      if (m_casv) check("R7 cas_o vs model", int'(cas_w), m_cas);
    end
  end

  task automatic wr(bit s, bit a, bit [7:0] d);
    @(negedge clk); wen = 1; sel = s; a0 = a; wd = d;
    @(negedge clk); wen = 0;
  endtask

  task automatic pulse(int i);
    @(negedge clk); irq[i] = 1'b1;
    @(negedge clk); irq[i] = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack(output int v, output int vv, output int cv, output int c);
    @(negedge clk); ack1 = 1;
    @(negedge clk); ack1 = 0;
    @(negedge clk); ack2 = 1; cv = int'(casv_w); c = int'(cas_w);
    @(negedge clk); ack2 = 0; v = int'(vec_w); vv = int'(vecv_w);
  endtask

  task automatic init(bit s, bit [7:0] base, bit [7:0] casc, bit [7:0] mode);
    wr(s, 0, 8'h11); wr(s, 1, base); wr(s, 1, casc); wr(s, 1, mode);
  endtask

  initial begin
    int v, vv, cv, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 int_o after reset", int'(int_w), 0);
    check("R1 vec_vld_o after reset", int'(vecv_w), 0);
    check("R1 cas_vld_o after reset", int'(casv_w), 0);
    pulse(6);
    check("R1 mask clear after reset", int'(int_w), 1);
    wr(0, 0, 8'h11);  // restart setup, drops the pending line

    wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
    init(1, 8'h70, 8'h02, 8'h01);

    pulse(2);
    check("R2 irq_i[2] ignored", int'(int_w), 0);
    @(negedge clk); irq[5] = 1'b1; @(negedge clk); @(negedge clk);
    check("R2 edge latched", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R6 vector line 5", v, 8'h25);
    check("R6 vector valid", vv, 1);
    wr(0, 0, 8'h20);
    check("R2 held level no second request", int'(int_w), 0);
    @(negedge clk); irq[5] = 1'b0;

    @(negedge clk); irq[6] = 1; irq[3] = 1;
    @(negedge clk); irq[6] = 0; irq[3] = 0; @(negedge clk);
    ack(v, vv, cv, c);
    check("R4 line 3 beats line 6", v, 8'h23);
    check("R4 lower request waits on in-service", int'(int_w), 0);
    wr(0, 0, 8'h20);
    check("R9 eoi releases waiting line", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R4 line 6 next", v, 8'h26);
    wr(0, 0, 8'h20);

    wr(0, 1, 8'h02);
    pulse(1);
    check("R3 masked line blocked", int'(int_w), 0);
    wr(0, 1, 8'h00);
    check("R3 unmask forwards latched line", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R3 vector line 1", v, 8'h21);
    wr(0, 0, 8'h20);

    pulse(12);
    check("R7 slave request reaches int_o", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R7 cascade code", c, 2);
    check("R7 cascade valid", cv, 1);
    check("R5 slave vector base", v, 8'h74);
    pulse(8);
    check("R4 cascade input in service blocks", int'(int_w), 0);
    wr(1, 0, 8'h20);
    check("R9 slave eoi leaves master in service", int'(int_w), 0);
    wr(0, 0, 8'h20);
    check("R9 master eoi releases slave", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R7 slave line 0", v, 8'h70);
    wr(1, 0, 8'h20); wr(0, 0, 8'h20);

    wr(0, 1, 8'h04);
    pulse(9);
    check("R8 master bit 2 masks slave", int'(int_w), 0);
    wr(0, 1, 8'h00);
    check("R8 unmask releases slave", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R8 slave line 1", v, 8'h71);
    wr(1, 0, 8'h20); wr(0, 0, 8'h20);

    init(1, 8'h70, 8'h03, 8'h01);
    pulse(10);
    ack(v, vv, cv, c);
    check("R7 identity mismatch no vector", vv, 0);
    wr(0, 0, 8'h20);
    init(1, 8'h70, 8'h02, 8'h01);
    check("R5 re-init clears slave request", int'(int_w), 0);

    wr(0, 1, 8'hFF);
    init(0, 8'h20, 8'h04, 8'h03);
    pulse(4);
    check("R5 start word clears mask", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R10 vector line 4", v, 8'h24);
    pulse(5);
    check("R10 auto eoi frees priority", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R10 vector line 5", v, 8'h25);

    init(0, 8'h20, 8'h04, 8'h11);
    pulse(11);
    ack(v, vv, cv, c);
    check("R11 slave line 3", v, 8'h73);
    pulse(8);
    check("R11 nested slave request", int'(int_w), 1);
    ack(v, vv, cv, c);
    check("R11 slave line 0", v, 8'h70);
    wr(1, 0, 8'h20); wr(1, 0, 8'h20); wr(0, 0, 8'h20); wr(0, 0, 8'h20);
    check("R9 all serviced", int'(int_w), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule